// File: doc/BRIEF.md
# Modem handshake control sequencer

This block is the modem-side (DCE) control logic of a point-to-point modem link. It watches two active-low requests from the attached terminal: terminal ready and request to send. It also watches a one-bit lock indication from the receiver, an active-low reset pin and a three-bit mode field. From these it produces three active-low answers: set ready, carrier detect and clear to send. It also drives an enable for a link-status LED.

Every input reaches the block asynchronously. Each one first passes through a multi-flop synchroniser. A small state machine then decides how far the handshake has progressed, and all outputs come straight from registers. The registers power up in the operational state, so the block works without any reset pulse. An unconnected reset pin reads High and counts as operational. The mode code 001 has the same effect as holding the reset pin Low.

Top module: `modem_hs_ctrl`

## Requirements
- R1: Every handshake signal is asserted when Low. After power-up with `rst_pin_n` High and a mode code other than 001, `dsr_n` goes Low and stays Low without any reset pulse being applied.
- R2: `dcd_n` goes Low only while `lock` is High and `dtr_n` is Low. A change on these inputs, set up before a rising edge, reaches `dcd_n` on the third rising edge.
- R3: When `dtr_n` goes High, `dcd_n` and `cts_n` go High on the third rising edge.
- R4: `cts_n` is Low only while `rts_n` is Low and `dcd_n` is Low. When `rts_n` returns High, `cts_n` goes High on the third rising edge while `dcd_n` stays Low.
- R5: `cts_n` never falls in the same cycle as `dcd_n`. It falls at the earliest one cycle after `dcd_n` is Low.
- R6: When `lock` falls, `dcd_n` and `cts_n` go High together on the same edge, the third one.
- R7: While `rst_pin_n` is held Low, `dsr_n`, `dcd_n` and `cts_n` are High and `led_en` is 0. After release, normal operation resumes.
- R8: When `mode` = 3'b001 (bit 0 set, bits 2 and 1 clear), the block behaves exactly as with the reset pin Low. Each of the other seven codes has no effect on the outputs.
- R9: `led_en` is 1 exactly while carrier detect is active, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, Low = reset |
| mode | input | 3 | Mode field; code 001 forces reset |
| dtr_n | input | 1 | Terminal ready from the terminal, active Low |
| rts_n | input | 1 | Request to send from the terminal, active Low |
| lock | input | 1 | Receiver link locked, active High |
| dsr_n | output | 1 | Set ready, active Low |
| dcd_n | output | 1 | Carrier detect, active Low |
| cts_n | output | 1 | Clear to send, active Low |
| led_en | output | 1 | Link LED enable, active High |

## Verification
The carrier path is tried three ways: with terminal ready alone, with lock alone, and with both present. This separates a correct AND of the two inputs from a design that follows only one of them. Two orderings are used to raise clear to send. In the first, request to send is already active when lock arrives, which exposes any same-cycle rise of clear to send alongside carrier detect. In the second, request to send is raised only after the carrier is up, and then released while the carrier is kept. The link is torn down three ways (lock loss, terminal-ready removal and the reset pin), and all eight mode codes are walked. Together these show that only code 001 resets the block and that teardown drops both outputs on the same edge.

// File: rtl/modem_hs_pkg.sv
package modem_hs_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_RESET_CODE = 3'b001;

  typedef enum logic [1:0] {
    LS_RESET   = 2'd0,
    LS_READY   = 2'd1,
    LS_CARRIER = 2'd2,
    LS_CLEAR   = 2'd3
  } link_state_e;
endpackage

// File: rtl/modem_hs_sync.sv
module modem_hs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[CHAIN_W-W-1:0], d};
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/modem_hs_reset.sv
module modem_hs_reset
  import modem_hs_pkg::*;
(
  input  logic              clk,
  input  logic              pin_n_s,
  input  logic [MODE_W-1:0] mode_s,
  output logic              rst
);
  logic req;
  logic rst_q = 1'b0;

  assign req = !pin_n_s || (mode_s == MODE_RESET_CODE);

  always_ff @(posedge clk) rst_q <= req;

  assign rst = rst_q;

  // R8
  mode_alias_chk: assert property (@(posedge clk)
    (mode_s == MODE_RESET_CODE) |=> rst);
  // R7
  pin_reset_chk: assert property (@(posedge clk)
    (!pin_n_s) |=> rst);
endmodule

// File: rtl/modem_hs_fsm.sv
module modem_hs_fsm
  import modem_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dtr_act,
  input  logic rts_act,
  input  logic lock_act,
  output logic dsr_n,
  output logic dcd_n,
  output logic cts_n,
  output logic led_en
);
  link_state_e state = LS_READY;
  link_state_e nxt;
  logic carrier_ok;

  assign carrier_ok = lock_act && dtr_act;

  always_comb begin
    if (rst)
      nxt = LS_RESET;
    else if (!carrier_ok)
      nxt = LS_READY;
    else if (rts_act && (state == LS_CARRIER || state == LS_CLEAR))
      nxt = LS_CLEAR;
    else
      nxt = LS_CARRIER;
  end

  logic dsr_q = 1'b1;
  logic dcd_q = 1'b1;
  logic cts_q = 1'b1;
  logic led_q = 1'b0;

  always_ff @(posedge clk) begin
    state <= nxt;
    dsr_q <= (nxt == LS_RESET);
    dcd_q <= !(nxt == LS_CARRIER || nxt == LS_CLEAR);
    cts_q <= (nxt != LS_CLEAR);
    led_q <= (nxt == LS_CARRIER || nxt == LS_CLEAR);
  end

  assign dsr_n  = dsr_q;
  assign dcd_n  = dcd_q;
  assign cts_n  = cts_q;
  assign led_en = led_q;

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (dsr_n && dcd_n && cts_n && !led_en));
  // R4
  cts_needs_dcd_chk: assert property (@(posedge clk) disable iff (rst)
    !cts_n |-> !dcd_n);
  // R5
  cts_after_dcd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cts_n) |-> $past(!dcd_n));
  // R6
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_act |=> (dcd_n && cts_n));
  // R3
  dtr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !dtr_act |=> dcd_n);
  // R9
  led_follow_chk: assert property (@(posedge clk)
    led_en == !dcd_n);
endmodule

// File: rtl/modem_hs_ctrl.sv
module modem_hs_ctrl
  import modem_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              dtr_n,
  input  logic              rts_n,
  input  logic              lock,
  output logic              dsr_n,
  output logic              dcd_n,
  output logic              cts_n,
  output logic              led_en
);
  localparam int CTRL_W = MODE_W + 1;
  localparam int TERM_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic [TERM_W-1:0] term_s;
  logic              rst;

  modem_hs_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES),
                  .INIT({1'b1, {MODE_W{1'b0}}})) u_ctrl_sync (
    .clk (clk),
    .d   ({rst_pin_n, mode}),
    .q   (ctrl_s)
  );

  modem_hs_sync #(.W(TERM_W), .STAGES(SYNC_STAGES),
                  .INIT(3'b110)) u_term_sync (
    .clk (clk),
    .d   ({dtr_n, rts_n, lock}),
    .q   (term_s)
  );

  modem_hs_reset u_reset (
    .clk     (clk),
    .pin_n_s (ctrl_s[CTRL_W-1]),
    .mode_s  (ctrl_s[MODE_W-1:0]),
    .rst     (rst)
  );

  modem_hs_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .dtr_act  (!term_s[2]),
    .rts_act  (!term_s[1]),
    .lock_act (term_s[0]),
    .dsr_n    (dsr_n),
    .dcd_n    (dcd_n),
    .cts_n    (cts_n),
    .led_en   (led_en)
  );
endmodule

// File: tb/modem_hs_ctrl_tb.sv
module modem_hs_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       dtr_n = 1'b1;
  logic       rts_n = 1'b1;
  logic       lock = 1'b0;
  logic       dsr_n, dcd_n, cts_n, led_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  modem_hs_ctrl u_dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .mode(mode),
    .dtr_n(dtr_n), .rts_n(rts_n), .lock(lock),
    .dsr_n(dsr_n), .dcd_n(dcd_n), .cts_n(cts_n), .led_en(led_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // inputs change and outputs are sampled on falling edges
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic ds, input logic dc,
                         input logic ct, input logic le);
    chk({tag, " dsr_n"}, dsr_n, ds);
    chk({tag, " dcd_n"}, dcd_n, dc);
    chk({tag, " cts_n"}, cts_n, ct);
    chk({tag, " led_en"}, led_en, le);
  endtask

  task automatic t_powerup_r1;
    cyc(6);
    chk_all("R1 power-up", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_carrier_r2;
    dtr_n = 1'b0; cyc(6);
    chk("R2 dtr alone dcd_n", dcd_n, 1'b1);
    dtr_n = 1'b1; lock = 1'b1; cyc(6);
    chk("R2 lock alone dcd_n", dcd_n, 1'b1);
    dtr_n = 1'b0;
    cyc(2);
    chk("R2 latency edge2 dcd_n", dcd_n, 1'b1);
    cyc(1);
    chk("R2 latency edge3 dcd_n", dcd_n, 1'b0);
    chk("R9 led on with carrier", led_en, 1'b1);
    chk("R2 cts_n idle", cts_n, 1'b1);
  endtask

  task automatic t_rts_late_r4;
    rts_n = 1'b0;
    cyc(2);
    chk("R4 cts edge2", cts_n, 1'b1);
    cyc(1);
    chk("R4 cts edge3", cts_n, 1'b0);
    rts_n = 1'b1;
    cyc(3);
    chk("R4 rts release cts_n", cts_n, 1'b1);
    chk("R4 rts release dcd_n kept", dcd_n, 1'b0);
  endtask

  task automatic t_lock_loss_r6;
    rts_n = 1'b0; cyc(6);
    chk("R6 pre cts_n", cts_n, 1'b0);
    lock = 1'b0;
    cyc(2);
    chk("R6 edge2 dcd_n", dcd_n, 1'b0);
    chk("R6 edge2 cts_n", cts_n, 1'b0);
    cyc(1);
    chk("R6 edge3 dcd_n", dcd_n, 1'b1);
    chk("R6 edge3 cts_n", cts_n, 1'b1);
    chk("R9 led off after loss", led_en, 1'b0);
  endtask

  task automatic t_order_r5;
    // rts already active when lock arrives
    lock = 1'b1;
    cyc(3);
    chk("R5 edge3 dcd_n", dcd_n, 1'b0);
    chk("R5 edge3 cts_n still high", cts_n, 1'b1);
    cyc(1);
    chk("R5 edge4 cts_n", cts_n, 1'b0);
  endtask

  task automatic t_dtr_drop_r3;
    dtr_n = 1'b1;
    cyc(2);
    chk("R3 edge2 dcd_n", dcd_n, 1'b0);
    cyc(1);
    chk("R3 edge3 dcd_n", dcd_n, 1'b1);
    chk("R3 edge3 cts_n", cts_n, 1'b1);
    chk("R1 dsr_n stays", dsr_n, 1'b0);
    // rts with no carrier must not clear to send
    cyc(6);
    chk("R4 rts without carrier cts_n", cts_n, 1'b1);
    dtr_n = 1'b0; cyc(6);
  endtask

  task automatic t_reset_pin_r7;
    chk_all("R7 before", 1'b0, 1'b0, 1'b0, 1'b1);
    rst_pin_n = 1'b0; cyc(6);
    chk_all("R7 held", 1'b1, 1'b1, 1'b1, 1'b0);
    rst_pin_n = 1'b1; cyc(8);
    chk_all("R7 released", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_modes_r8;
    for (int c = 0; c < 8; c++) begin
      mode = 3'(c); cyc(7);
      if (c == 1) chk_all($sformatf("R8 mode %0d", c), 1'b1, 1'b1, 1'b1, 1'b0);
      else        chk_all($sformatf("R8 mode %0d", c), 1'b0, 1'b0, 1'b0, 1'b1);
      mode = 3'b000; cyc(8);
    end
  endtask

  initial begin
    t_powerup_r1();
    t_carrier_r2();
    t_rts_late_r4();
    t_lock_loss_r6();
    t_order_r5();
    t_dtr_drop_r3();
    t_reset_pin_r7();
    t_modes_r8();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule